// File: doc/BRIEF.md
# Packet Framing Transmitter

The block takes payload bytes from a 64-entry transmit FIFO and sends them as a complete on-air frame, one byte per handshake, to a downstream modulator. A frame holds a run of 0xAA preamble bytes, a two-byte sync word, up to four header bytes, an optional length byte, the payload taken from the FIFO, and a 16-bit CRC. Preamble count, sync word, header count and contents, length mode, CRC polynomial and CRC coverage are all set by configuration inputs. These inputs are captured when a frame starts, so changing them while a frame is being sent has no effect on that frame.

Sending begins on a start strobe. When automatic mode is on, sending instead begins as soon as the FIFO fill level reaches a programmable threshold. The block reports three conditions as one-cycle pulses. The first marks a completed frame. The second marks a payload that asked for more bytes than the FIFO held. The third marks a write that arrived while the FIFO was full. A clear input empties the FIFO.

Top module: `pkt_framer`

## Requirements
- R1: A frame opens with `pre_len`+1 preamble bytes, each 0xAA, so `pre_len` 0..511 gives 1..512 bytes.
- R2: The preamble is followed by the 16-bit `sync_word`, high byte first.
- R3: The sync word is followed by `hdr_cnt` header bytes, taken from `hdr_bytes` starting at bits [31:24] and moving to lower bytes. A count of 0 sends no header. A count above 4 sends 4 bytes.
- R4: When `var_len`=1, one byte equal to `pay_len` follows the header. When `var_len`=0, no length byte is sent.
- R5: The header and length are followed by `pay_len` payload bytes, in the order they were written to the FIFO. Each payload byte is removed from the FIFO as it is accepted.
- R6: The frame ends with a 16-bit CRC, high byte first. The CRC starts at 0xFFFF, is not reflected, and has no final XOR. `crc_sel` chooses the polynomial: 0 selects 0x1021, 1 selects 0x8005, 2 selects 0x3D65 and 3 selects 0x8BB7. When `crc_all`=0 the CRC covers the payload only. When `crc_all`=1 it covers the sync, header, length and payload bytes.
- R7: The FIFO holds 64 bytes. A write to a full FIFO is dropped, and `overflow` pulses for one cycle on the next cycle.
- R8: If a payload byte is needed while the FIFO is empty, `out_valid` stays low and `underflow` pulses for one cycle. The block then returns to idle without pulsing `pkt_sent` and sends nothing further of that frame.
- R9: `pkt_sent` pulses for exactly one cycle, on the cycle after the last CRC byte is accepted. `out_valid` is low during that cycle.
- R10: When `auto_tx_en`=1, an idle block starts a frame once the FIFO count is at least `afull_thr`. When `auto_tx_en`=0, only `tx_start` starts a frame.
- R11: While `fifo_clr`=1, the FIFO is emptied and writes are dropped. After `fifo_clr` returns to 0, only bytes written from then on are sent.
- R12: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` stay unchanged on the next cycle.
- R13: After reset, `out_valid`, `pkt_sent`, `underflow` and `overflow` are 0 and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | FIFO write byte |
| fifo_clr | input | 1 | Empties the FIFO while high |
| tx_start | input | 1 | Starts a frame when idle |
| auto_tx_en | input | 1 | Enables threshold-triggered start |
| afull_thr | input | 6 | Fill threshold for automatic start |
| pre_len | input | 9 | Preamble byte count minus one |
| sync_word | input | 16 | Sync word |
| hdr_cnt | input | 3 | Header byte count (clamped to 4) |
| hdr_bytes | input | 32 | Header contents, first byte in [31:24] |
| var_len | input | 1 | Send the length byte |
| pay_len | input | 8 | Payload byte count |
| crc_sel | input | 2 | CRC polynomial select |
| crc_all | input | 1 | CRC over sync, header, length and payload |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts the byte |
| pkt_sent | output | 1 | Frame completed pulse |
| underflow | output | 1 | Payload ran past FIFO contents pulse |
| overflow | output | 1 | Write to full FIFO dropped pulse |

## Verification
A wrong field counter or a wrong next-field choice shows up right away in the byte stream. It appears as one preamble byte too many or too few, a missing or extra header or length byte, or a sync byte where a header byte should be. Each of these is caught at the first misplaced byte. A wrong CRC register, polynomial or coverage choice stays hidden until the two trailing bytes of the frame. The scoreboard then compares them against a bit-serial reference. FIFO pointer or count faults show up as reordered or stale payload bytes, as a missing or extra `overflow` pulse, or as an `underflow` pulse that arrives at the wrong payload position.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;

    localparam int BYTE_W  = 8;
    localparam int PRE_W   = 9;
    localparam int HDR_MAX = 4;
    localparam int HDR_CW  = 3;
    localparam int LEN_W   = 8;
    localparam int CRC_W   = 16;

    typedef enum logic [2:0] {
        F_IDLE, F_PRE, F_SYNC, F_HDR, F_LEN, F_PAY, F_CRC
    } field_e;

    typedef struct packed {
        logic [PRE_W-1:0]          pre_last;
        logic [CRC_W-1:0]          sync;
        logic [HDR_CW-1:0]         hdr_n;
        logic [HDR_MAX*BYTE_W-1:0] hdr;
        logic                      var_len;
        logic [LEN_W-1:0]          pay_len;
        logic [1:0]                crc_sel;
        logic                      crc_all;
    } frame_cfg_t;

    function automatic logic [CRC_W-1:0] poly_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 16'h1021;
            2'd1:    return 16'h8005;
            2'd2:    return 16'h3D65;
            default: return 16'h8BB7;
        endcase
    endfunction

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d,
                                                  input logic [CRC_W-1:0] poly);
        logic [CRC_W-1:0] r;
        r = c ^ {d, 8'h00};
        for (int i = 0; i < BYTE_W; i++) begin
            r = r[CRC_W-1] ? ((r << 1) ^ poly) : (r << 1);
        end
        return r;
    endfunction

    function automatic field_e after_len(input frame_cfg_t c);
        return (c.pay_len != '0) ? F_PAY : F_CRC;
    endfunction

    function automatic field_e after_hdr(input frame_cfg_t c);
        return c.var_len ? F_LEN : after_len(c);
    endfunction

    function automatic field_e after_sync(input frame_cfg_t c);
        return (c.hdr_n != '0) ? F_HDR : after_hdr(c);
    endfunction

endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          ovf
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic          full, wr_ok, rd_ok;

    assign full  = (cnt_q == CW'(DEPTH));
    assign wr_ok = wr_en && !full && !clr;
    assign rd_ok = pop && (cnt_q != '0) && !clr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= wr_en && full;
            if (wr_ok) wp_q <= bump(wp_q);
            if (rd_ok) rp_q <= bump(rp_q);
            case ({wr_ok, rd_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = mem[rp_q];
    assign count = cnt_q;
    assign ovf   = ovf_q;

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));
    p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !clr && !pop) |=> (cnt_q == $past(cnt_q)));
    p_clear_empty_r11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/crc16_unit.sv
module crc16_unit
    import pkt_framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              en,
    input  logic [1:0]        sel,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init)  crc_q <= '1;
        else if (en)      crc_q <= crc_step(crc_q, din, poly_of(sel));
    end

    assign crc = crc_q;
endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import pkt_framer_pkg::*;
#(
    parameter int CW    = 7,
    localparam int THRW = CW - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_start,
    input  logic              auto_en,
    input  logic [THRW-1:0]   thr,
    input  logic [CW-1:0]     fifo_count,
    input  logic [BYTE_W-1:0] fifo_head,
    input  frame_cfg_t        cfg_in,
    input  logic [CRC_W-1:0]  crc_val,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              pop,
    output logic              crc_init,
    output logic              crc_en,
    output logic [1:0]        crc_sel,
    output logic              pkt_sent,
    output logic              underflow
);
    field_e               st_q;
    logic [PRE_W-1:0]     cnt_q;
    frame_cfg_t           cfg_q;
    logic                 sent_q, uflow_q;
    logic                 start_req, acc, last, covered, fifo_empty;
    field_e               nxt;
    logic [HDR_MAX*BYTE_W-1:0] hdr_sh;

    assign fifo_empty = (fifo_count == '0);
    assign start_req  = tx_start || (auto_en && (fifo_count >= {1'b0, thr}));
    assign hdr_sh     = cfg_q.hdr << (BYTE_W * cnt_q[1:0]);

    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        last      = 1'b0;
        nxt       = F_IDLE;
        unique case (st_q)
            F_PRE: begin
                out_valid = 1'b1;
                out_data  = 8'hAA;
                last      = (cnt_q == cfg_q.pre_last);
                nxt       = F_SYNC;
            end
            F_SYNC: begin
                out_valid = 1'b1;
                out_data  = cnt_q[0] ? cfg_q.sync[7:0] : cfg_q.sync[15:8];
                last      = cnt_q[0];
                nxt       = after_sync(cfg_q);
            end
            F_HDR: begin
                out_valid = 1'b1;
                out_data  = hdr_sh[HDR_MAX*BYTE_W-1 -: BYTE_W];
                last      = ((cnt_q + 1'b1) == PRE_W'(cfg_q.hdr_n));
                nxt       = after_hdr(cfg_q);
            end
            F_LEN: begin
                out_valid = 1'b1;
                out_data  = cfg_q.pay_len;
                last      = 1'b1;
                nxt       = after_len(cfg_q);
            end
            F_PAY: begin
                out_valid = !fifo_empty;
                out_data  = fifo_head;
                last      = ((cnt_q + 1'b1) == PRE_W'(cfg_q.pay_len));
                nxt       = F_CRC;
            end
            F_CRC: begin
                out_valid = 1'b1;
                out_data  = cnt_q[0] ? crc_val[7:0] : crc_val[15:8];
                last      = cnt_q[0];
                nxt       = F_IDLE;
            end
            default: ;
        endcase
    end

    assign acc      = out_valid && out_ready;
    assign covered  = (st_q == F_PAY) ||
                      (cfg_q.crc_all && (st_q inside {F_SYNC, F_HDR, F_LEN}));
    assign crc_en   = acc && covered;
    assign pop      = acc && (st_q == F_PAY);
    assign crc_init = (st_q == F_IDLE) && start_req;
    assign crc_sel  = cfg_q.crc_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= F_IDLE;
            cnt_q   <= '0;
            cfg_q   <= '0;
            sent_q  <= 1'b0;
            uflow_q <= 1'b0;
        end else begin
            sent_q  <= 1'b0;
            uflow_q <= 1'b0;
            if (st_q == F_IDLE) begin
                if (start_req) begin
                    cfg_q       <= cfg_in;
                    cfg_q.hdr_n <= (cfg_in.hdr_n > HDR_CW'(HDR_MAX)) ?
                                   HDR_CW'(HDR_MAX) : cfg_in.hdr_n;
                    st_q        <= F_PRE;
                    cnt_q       <= '0;
                end
            end else if ((st_q == F_PAY) && fifo_empty) begin
                st_q    <= F_IDLE;
                uflow_q <= 1'b1;
            end else if (acc) begin
                if (last) begin
                    st_q   <= nxt;
                    cnt_q  <= '0;
                    sent_q <= (st_q == F_CRC);
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign pkt_sent  = sent_q;
    assign underflow = uflow_q;

    p_sent_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        pkt_sent |=> !pkt_sent);
    p_sent_idle_r9: assert property (@(posedge clk) disable iff (rst)
        pkt_sent |-> !out_valid);
    p_uflow_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        underflow |-> !out_valid);
    p_uflow_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(pkt_sent && underflow));
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
    import pkt_framer_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    localparam int THR_W     = $clog2(FIFO_DEPTH),
    localparam int CNT_W     = THR_W + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [BYTE_W-1:0]         wr_data,
    input  logic                      fifo_clr,
    input  logic                      tx_start,
    input  logic                      auto_tx_en,
    input  logic [THR_W-1:0]          afull_thr,
    input  logic [PRE_W-1:0]          pre_len,
    input  logic [CRC_W-1:0]          sync_word,
    input  logic [HDR_CW-1:0]         hdr_cnt,
    input  logic [HDR_MAX*BYTE_W-1:0] hdr_bytes,
    input  logic                      var_len,
    input  logic [LEN_W-1:0]          pay_len,
    input  logic [1:0]                crc_sel,
    input  logic                      crc_all,
    output logic                      out_valid,
    output logic [BYTE_W-1:0]         out_data,
    input  logic                      out_ready,
    output logic                      pkt_sent,
    output logic                      underflow,
    output logic                      overflow
);
    frame_cfg_t        cfg_in;
    logic [CNT_W-1:0]  f_count;
    logic [BYTE_W-1:0] f_head;
    logic              f_pop;
    logic              c_init, c_en;
    logic [1:0]        c_sel;
    logic [CRC_W-1:0]  c_val;

    always_comb begin
        cfg_in.pre_last = pre_len;
        cfg_in.sync     = sync_word;
        cfg_in.hdr_n    = hdr_cnt;
        cfg_in.hdr      = hdr_bytes;
        cfg_in.var_len  = var_len;
        cfg_in.pay_len  = pay_len;
        cfg_in.crc_sel  = crc_sel;
        cfg_in.crc_all  = crc_all;
    end

    tx_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk(clk), .rst(rst), .clr(fifo_clr), .wr_en(wr_en), .wr_data(wr_data),
        .pop(f_pop), .head(f_head), .count(f_count), .ovf(overflow)
    );

    crc16_unit u_crc (
        .clk(clk), .rst(rst), .init(c_init), .en(c_en), .sel(c_sel),
        .din(out_data), .crc(c_val)
    );

    frame_seq #(.CW(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .tx_start(tx_start), .auto_en(auto_tx_en),
        .thr(afull_thr), .fifo_count(f_count), .fifo_head(f_head),
        .cfg_in(cfg_in), .crc_val(c_val), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .pop(f_pop),
        .crc_init(c_init), .crc_en(c_en), .crc_sel(c_sel),
        .pkt_sent(pkt_sent), .underflow(underflow)
    );

    p_stall_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !fifo_clr) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/pkt_framer_bench.sv
module pkt_framer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst = 1'b1;
    logic        wr_en = 0, fifo_clr = 0, tx_start = 0, auto_tx_en = 0;
    logic [7:0]  wr_data = 0;
    logic [5:0]  afull_thr = 0;
    logic [8:0]  pre_len = 0;
    logic [15:0] sync_word = 16'h2DD4;
    logic [2:0]  hdr_cnt = 0;
    logic [31:0] hdr_bytes = 0;
    logic        var_len = 0, crc_all = 0;
    logic [7:0]  pay_len = 0;
    logic [1:0]  crc_sel = 0;
    logic        out_ready = 1'b1, bp_mode = 1'b0;
    logic        out_valid, pkt_sent, underflow, overflow;
    logic [7:0]  out_data;

    int n_chk = 0, n_fail = 0, n_sent = 0, n_uflow = 0, n_ovf = 0;
    int s_sent = 0, s_uflow = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] model[$];
    bit         stall_pend = 0;
    logic [7:0] stall_data;

    pkt_framer u_pkt_framer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .fifo_clr(fifo_clr),
        .tx_start(tx_start), .auto_tx_en(auto_tx_en), .afull_thr(afull_thr),
        .pre_len(pre_len), .sync_word(sync_word), .hdr_cnt(hdr_cnt),
        .hdr_bytes(hdr_bytes), .var_len(var_len), .pay_len(pay_len),
        .crc_sel(crc_sel), .crc_all(crc_all), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready), .pkt_sent(pkt_sent),
        .underflow(underflow), .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d,
                                            input logic [1:0] sel);
        logic [15:0] p;
        logic fb;
        p = (sel == 0) ? 16'h1021 : (sel == 1) ? 16'h8005 :
            (sel == 2) ? 16'h3D65 : 16'h8BB7;
        for (int b = 7; b >= 0; b--) begin
            fb = c[15] ^ d[b];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ p;
        end
        return c;
    endfunction

    // Scoreboard monitor: compares every accepted byte and counts pulses
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_pend) begin
                check(out_valid && out_data == stall_data, "R12 stall hold",
                      {out_valid, out_data}, {1'b1, stall_data});
                stall_pend = 0;
            end
            if (out_valid && !out_ready) begin
                stall_pend = 1;
                stall_data = out_data;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0)
                    check(0, "R5 unexpected byte", out_data, 0);
                else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(out_data == e, t, out_data, e);
                end
            end
            if (pkt_sent)  n_sent++;
            if (underflow) n_uflow++;
            if (overflow)  n_ovf++;
        end
    end

    // Ready driver: always high, or a stalling pattern
    initial begin
        logic [2:0] ph = 0;
        forever begin
            @(posedge clk); #1;
            ph++;
            out_ready = bp_mode ? (ph[1:0] != 2'd1 && ph != 3'd6) : 1'b1;
        end
    end

    task automatic push(input logic [7:0] b, input string t);
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    task automatic wr_byte(input logic [7:0] d);
        wr_en = 1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
        if (model.size() < 64) model.push_back(d);
    endtask

    task automatic snap();
        s_sent = n_sent; s_uflow = n_uflow;
    endtask

    // Driver: expected frame from the requirements and the FIFO model
    task automatic expect_frame();
        logic [15:0] c = 16'hFFFF;
        int hn = (hdr_cnt > 4) ? 4 : hdr_cnt;
        for (int i = 0; i <= pre_len; i++) push(8'hAA, "R1 preamble");
        push(sync_word[15:8], "R2 sync hi");
        push(sync_word[7:0], "R2 sync lo");
        if (crc_all) begin
            c = ref_crc(c, sync_word[15:8], crc_sel);
            c = ref_crc(c, sync_word[7:0], crc_sel);
        end
        for (int i = 0; i < hn; i++) begin
            automatic logic [7:0] h = hdr_bytes[31 - 8*i -: 8];
            push(h, "R3 header");
            if (crc_all) c = ref_crc(c, h, crc_sel);
        end
        if (var_len) begin
            push(pay_len, "R4 length");
            if (crc_all) c = ref_crc(c, pay_len, crc_sel);
        end
        for (int i = 0; i < pay_len; i++) begin
            automatic logic [7:0] p;
            if (model.size() == 0) return;
            p = model.pop_front();
            push(p, "R5 payload");
            c = ref_crc(c, p, crc_sel);
        end
        push(c[15:8], "R6 crc hi");
        push(c[7:0], "R6 crc lo");
    endtask

    task automatic go();
        snap();
        expect_frame();
        tx_start = 1;
        @(posedge clk); #1;
        tx_start = 0;
    endtask

    task automatic wait_end(input bit want_sent);
        int t = 0;
        while (n_sent == s_sent && n_uflow == s_uflow && t < 20000) begin
            @(posedge clk); t++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5 bytes left", exp_q.size(), 0);
        check((n_sent - s_sent) == int'(want_sent), "R9 sent pulses", n_sent - s_sent, want_sent);
        check((n_uflow - s_uflow) == int'(!want_sent), "R8 underflow pulses",
              n_uflow - s_uflow, !want_sent);
        check(!out_valid, "R9 idle after frame", out_valid, 0);
        exp_q.delete(); tag_q.delete();
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R13 reset state
        check(!out_valid && !pkt_sent && !underflow && !overflow, "R13 reset outputs",
              {out_valid, pkt_sent, underflow, overflow}, 0);
        @(posedge clk); #1;

        // Frame A: CCITT, payload-only CRC, 4 preamble, 2 header, length byte
        pre_len = 3; hdr_cnt = 2; hdr_bytes = 32'hA1B2C3D4; var_len = 1;
        pay_len = 5; crc_sel = 0; crc_all = 0;
        for (int i = 0; i < 5; i++) wr_byte(8'h10 + 8'(i));
        go(); wait_end(1);

        // Frame B: CRC-16 over whole packet, 4 header, no length, 1 preamble, stalls (R12)
        bp_mode = 1; pre_len = 0; hdr_cnt = 4; var_len = 0; pay_len = 6;
        crc_sel = 1; crc_all = 1; hdr_bytes = 32'h0102A5FE;
        for (int i = 0; i < 6; i++) wr_byte(8'hF0 ^ 8'(i * 37));
        go(); wait_end(1);

        // Frames C/D: polynomials 2 and 3, no header, new sync
        sync_word = 16'h1234; hdr_cnt = 0; var_len = 1; pay_len = 3;
        for (int s = 2; s < 4; s++) begin
            crc_sel = 2'(s); crc_all = (s == 3);
            for (int i = 0; i < 3; i++) wr_byte(8'(s * 50 + i));
            go(); wait_end(1);
        end
        bp_mode = 0;

        // R7 overflow: 65 writes, last dropped; R3 header count 7 clamps to 4
        snap();
        begin
            int o0 = n_ovf;
            for (int i = 0; i < 65; i++) wr_byte(8'(i * 3 + 1));
            repeat (2) @(negedge clk);
            check(n_ovf - o0 == 1, "R7 overflow pulse", n_ovf - o0, 1);
        end
        @(posedge clk); #1;
        pre_len = 0; hdr_cnt = 7; var_len = 0; pay_len = 64; crc_sel = 0; crc_all = 0;
        go(); wait_end(1);

        // R8 underflow: 2 bytes present, 5 requested
        pre_len = 2; hdr_cnt = 1; var_len = 1; pay_len = 5;
        wr_byte(8'h5A); wr_byte(8'hC3);
        go(); wait_end(0);
        repeat (4) @(negedge clk);
        check(!out_valid, "R8 nothing after underflow", out_valid, 0);
        @(posedge clk); #1;

        // R10 no start without strobe when automatic mode is off
        auto_tx_en = 0; afull_thr = 2;
        wr_byte(8'h99); wr_byte(8'h98); wr_byte(8'h97);
        repeat (8) @(negedge clk);
        check(!out_valid, "R10 waits for strobe", out_valid, 0);
        @(posedge clk); #1;

        // R11 clear, with a write during clear dropped
        fifo_clr = 1; wr_en = 1; wr_data = 8'h77;
        @(posedge clk); #1;
        fifo_clr = 0; wr_en = 0;
        model.delete();
        wr_byte(8'h3C); wr_byte(8'h4D);
        pay_len = 2; hdr_cnt = 0; pre_len = 1;
        go(); wait_end(1);   // R11 payload must be 3C 4D only

        // R10 automatic start at threshold 4
        auto_tx_en = 1; afull_thr = 4; pay_len = 4; crc_sel = 3; crc_all = 1;
        wr_byte(8'hE1); wr_byte(8'hE2); wr_byte(8'hE3);
        repeat (8) @(negedge clk);
        check(!out_valid, "R10 below threshold idle", out_valid, 0);
        @(posedge clk); #1;
        snap();
        wr_byte(8'hE4);
        expect_frame();
        wait_end(1);
        auto_tx_en = 0;

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule